// File: doc/BRIEF.md
# Eight-Pin Banked I/O Port Controller

This block manages a single 8-bit I/O port. Every bit position drives one identical pin slice. A CPU reaches eight 8-bit registers through a small bus that carries a bank bit and a 2-bit address. Four registers sit in each of two banks.

The registers are:
- an output latch;
- an interrupt enable;
- a routing select;
- three drive-mode planes, which together give each pin a 3-bit mode;
- two trigger planes, which together give each pin a 2-bit interrupt trigger.

Pad levels pass through a two-flop synchronizer before they are used. A read of the output-latch address returns these synchronized levels, not the stored latch. The read also captures the levels as the reference for change detection.

When a pin's routing select is set, the pin is bypassed: its output comes from a separate per-pin source that an on-chip peripheral drives, not from the latch. Each pin raises a request when its trigger condition holds and its enable bit is set. One port-level request combines the per-pin requests.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the registers hold these values:
  - `0x00`: output latch, interrupt enable, routing select, mode plane 0, and both trigger planes.
  - `0xFF`: mode planes 1 and 2.

  As a result, every pin reports mode `3'b110` with `pin_oe` low. `pin_out`, `pin_glb_sel`, `pin_irq` and `port_irq` are all 0.
- R2: Registers are selected by `{bus_bank, bus_addr}`:
  - `0_00`: output latch
  - `0_01`: interrupt enable
  - `0_10`: routing select
  - `0_11`: mode plane 2
  - `1_00`: mode plane 0
  - `1_01`: mode plane 1
  - `1_10`: trigger plane 0
  - `1_11`: trigger plane 1

  A write on a rising edge with `bus_wr` high updates the selected register. `bus_rdata` returns the selected register combinationally, except at address `0_00`.
- R3: A write to the output latch appears on `pin_out` one clock later for every pin whose routing select is clear.
- R4: Reading address `0_00` returns the pad levels sampled two rising edges earlier through a two-flop synchronizer. It never returns the stored latch.
- R5: `pin_mode[3n+2:3n]` equals `{plane2[n], plane1[n], plane0[n]}`.
- R6: `pin_oe[n]` is low when pin n's mode is `3'b010` or `3'b110`, and high for every other mode.
- R7: For a pin with routing select set, `pin_glb_sel[n]` is 1 and `pin_out[n]` follows `glb_out_in[n]`.
- R8: The trigger code for pin n is `{plane1[n], plane0[n]}`:
  - `00`: no trigger
  - `01`: synchronized level high
  - `10`: synchronized level low

  `pin_irq[n]` is the trigger condition ANDed with enable bit n.
- R9: Trigger code `11` works as follows:
  - A flag sets on the cycle after the synchronized level differs from the level captured by the last read of `0_00`.
  - The flag stays set even if the pad returns to its old level.
  - A read of `0_00` clears the flag and captures the current level as the new reference.
- R10: `port_irq` is high exactly when any bit of `pin_irq` is high.
- R11: Reads of any address other than `0_00` have no side effect on change detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_bank | input | 1 | Register bank select |
| bus_addr | input | 2 | Register address within bank |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on `0_00` only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 8 | Raw pad levels |
| glb_out_in | input | 8 | Per-pin output source used when routing select is set |
| pin_out | output | 8 | Per-pin output data |
| pin_oe | output | 8 | Per-pin output enable |
| pin_mode | output | 24 | Per-pin 3-bit drive mode |
| pin_glb_sel | output | 8 | Per-pin routing select |
| pin_irq | output | 8 | Per-pin interrupt request |
| port_irq | output | 1 | Port interrupt request |

## Verification
The checker relies on the bus strobes being synchronous to `clk`. It also relies on at most one register access being issued per cycle.

Its synchronizer property holds only when the read data is compared with the pad value two samples back, counted from the second cycle after reset. The bench respects these limits in two ways:
- It drives the bus and pads only on falling edges.
- It holds `pad_in` stable across every read and for three cycles after each pad change, so the bench model's synchronized level and change flags are settled before anything is compared.

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_bank,
  input  logic [1:0]     bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic [W-1:0]   pad_in,
  input  logic [W-1:0]   glb_out_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe,
  output logic [3*W-1:0] pin_mode,
  output logic [W-1:0]   pin_glb_sel,
  output logic [W-1:0]   pin_irq,
  output logic           port_irq
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] lat, ien, gsel, pl0, pl1, pl2, trg0, trg1;
  logic [W-1:0] sy1, sy2, ref_lvl, chg;
  logic [2:0]   sel;
  logic         rd_lat;

  assign sel    = {bus_bank, bus_addr};
  assign rd_lat = bus_rd && sel == 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= ZERO;
      ien  <= ZERO;
      gsel <= ZERO;
      pl2  <= ONES;
      pl0  <= ZERO;
      pl1  <= ONES;
      trg0 <= ZERO;
      trg1 <= ZERO;
    end else if (bus_wr) begin
      case (sel)
        3'b000: lat  <= bus_wdata;
        3'b001: ien  <= bus_wdata;
        3'b010: gsel <= bus_wdata;
        3'b011: pl2  <= bus_wdata;
        3'b100: pl0  <= bus_wdata;
        3'b101: pl1  <= bus_wdata;
        3'b110: trg0 <= bus_wdata;
        default: trg1 <= bus_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1     <= ZERO;
      sy2     <= ZERO;
      ref_lvl <= ZERO;
      chg     <= ZERO;
    end else begin
      sy1 <= pad_in;
      sy2 <= sy1;
      if (rd_lat) begin
        ref_lvl <= sy2;
        chg     <= ZERO;
      end else begin
        chg <= chg | (sy2 ^ ref_lvl);
      end
    end
  end

  always_comb begin
    case (sel)
      3'b000: bus_rdata = sy2;
      3'b001: bus_rdata = ien;
      3'b010: bus_rdata = gsel;
      3'b011: bus_rdata = pl2;
      3'b100: bus_rdata = pl0;
      3'b101: bus_rdata = pl1;
      3'b110: bus_rdata = trg0;
      default: bus_rdata = trg1;
    endcase
  end

  for (genvar n = 0; n < W; n++) begin : g_pin
    logic cond;
    assign pin_mode[3*n +: 3] = {pl2[n], pl1[n], pl0[n]};
    always_comb begin
      case ({trg1[n], trg0[n]})
        2'b01:   cond = sy2[n];
        2'b10:   cond = ~sy2[n];
        2'b11:   cond = chg[n];
        default: cond = 1'b0;
      endcase
    end
    assign pin_irq[n] = ien[n] & cond;
  end

  assign pin_oe      = ~(pl1 & ~pl0);
  assign pin_out     = (gsel & glb_out_in) | (~gsel & lat);
  assign pin_glb_sel = gsel;
  assign port_irq    = |pin_irq;
endmodule

module gpio_port_ctrl_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_bank,
  input logic [1:0]     bus_addr,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [W-1:0]   bus_wdata,
  input logic [W-1:0]   bus_rdata,
  input logic [W-1:0]   pad_in,
  input logic [W-1:0]   pin_out,
  input logic [W-1:0]   pin_glb_sel,
  input logic [3*W-1:0] pin_mode,
  input logic [W-1:0]   pin_irq
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (pin_mode == {W{3'b110}}));

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_bank && bus_addr == 2'd0 && !$isunknown(bus_wdata))
    |=> ((pin_out & ~pin_glb_sel) == ($past(bus_wdata) & ~pin_glb_sel)));

  // R4
  sync_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && bus_rd && !bus_bank && bus_addr == 2'd0)
    |-> (bus_rdata == $past(pad_in, 2)));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_bank && bus_addr == 2'd1 && bus_wdata == '0)
    |=> (pin_irq == '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_bank = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, pad_in = 0, glb_out_in = 0;
  logic [7:0] bus_rdata, pin_out, pin_oe, pin_glb_sel, pin_irq;
  logic [23:0] pin_mode;
  logic port_irq;
  int checks = 0, failures = 0;

  logic [7:0] m [8];
  logic [7:0] pad_m, ref_m, chg_m;

  always #2.5 clk = ~clk;

  gpio_port_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] e_mode();
    logic [23:0] r;
    for (int n = 0; n < 8; n++) r[3*n +: 3] = {m[3][n], m[5][n], m[4][n]};
    return r;
  endfunction

  function automatic logic [7:0] e_oe();
    logic [7:0] r;
    logic [23:0] md = e_mode();
    for (int n = 0; n < 8; n++) r[n] = !(md[3*n +: 3] == 3'b010 || md[3*n +: 3] == 3'b110);
    return r;
  endfunction

  function automatic logic [7:0] e_out();
    logic [7:0] r;
    for (int n = 0; n < 8; n++) r[n] = m[2][n] ? glb_out_in[n] : m[0][n];
    return r;
  endfunction

  function automatic logic [7:0] e_irq();
    logic [7:0] r;
    for (int n = 0; n < 8; n++) begin
      case ({m[7][n], m[6][n]})
        2'b01: r[n] = pad_m[n];
        2'b10: r[n] = !pad_m[n];
        2'b11: r[n] = chg_m[n];
        default: r[n] = 1'b0;
      endcase
      r[n] = r[n] & m[1][n];
    end
    return r;
  endfunction

  task automatic check_outputs(string tag);
    chk({tag, " R5 mode"}, pin_mode, e_mode());
    chk({tag, " R6 oe"}, pin_oe, e_oe());
    chk({tag, " R3/R7 out"}, pin_out, e_out());
    chk({tag, " R7 sel"}, pin_glb_sel, m[2]);
    chk({tag, " R8/R9 irq"}, pin_irq, e_irq());
    chk({tag, " R10 port"}, port_irq, |e_irq());
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    {bus_bank, bus_addr} = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    if (a != 0) m[a] = d; else m[0] = d;
  endtask

  task automatic rd(logic [2:0] a, string req);
    @(negedge clk);
    {bus_bank, bus_addr} = a; bus_rd = 1;
    #1 chk(req, bus_rdata, (a == 0) ? pad_m : m[a]);
    @(negedge clk);
    bus_rd = 0;
    if (a == 0) begin ref_m = pad_m; chg_m = 0; end
  endtask

  task automatic set_pad(logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
    pad_m = v;
    chg_m = chg_m | (pad_m ^ ref_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    m = '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00};
    pad_m = 0; ref_m = 0; chg_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", pin_mode, {8{3'b110}});
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 irq", {pin_irq, port_irq}, 9'h0);
    for (int a = 1; a < 8; a++) rd(a[2:0], "R1 R2 reset readback");
    // R4 read returns pads, not latch
    wr(0, 8'hA5);
    chk("R3 latch out", pin_out, 8'hA5);
    set_pad(8'h3C);
    rd(0, "R4 pad read");
    // R6 mode 010 is high-Z, 011 drives
    wr(4, 8'h02); wr(5, 8'h03); wr(3, 8'h00);
    chk("R6 oe codes", pin_oe, 8'hFE);
    // R7 bypass
    glb_out_in = 8'h0F; wr(2, 8'hF0);
    check_outputs("R7 bypass");
    // R8 level triggers
    wr(1, 8'hFF); wr(6, 8'h0F); wr(7, 8'hF0);
    set_pad(8'h81);
    check_outputs("R8 level");
    // R9 change sticky, cleared by data read, R11 other reads no effect
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd(0, "R9 arm");
    check_outputs("R9 armed");
    chk("R9 clear", pin_irq, 8'h00);
    set_pad(8'h80);
    chk("R9 set", pin_irq, 8'h01);
    set_pad(8'h81);
    chk("R9 sticky", pin_irq, 8'h01);
    rd(1, "R11 other read");
    chk("R11 no clear", pin_irq, 8'h01);
    rd(0, "R9 clear read");
    chk("R9 cleared", pin_irq, 8'h00);
    // random phase
    for (int i = 0; i < 400; i++) begin
      v = 8'($urandom);
      case ($urandom % 5)
        0, 1: wr(3'($urandom), v);
        2: set_pad(v);
        3: rd(3'($urandom), "R2 R4 random read");
        default: begin @(negedge clk); glb_out_in = v; @(negedge clk); end
      endcase
      check_outputs("rand");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule